// File: doc/BRIEF.md
# Programmed-I/O Command Sequencer

This block runs one bus transaction at a time on software's behalf. Software fills a small register map over a simple register port. It writes a byte count, then a target address, then the outgoing data words (for writes), then an opcode, and finally sets a go bit. The sequencer decodes the opcode and then does one of two things. It can hand a read, a write or a write-then-read to an external serial bus engine through a request/response port. It can also move one word between the data window and a local bank of 256 registers.

The data window holds sixteen 32-bit words, so a single transfer moves at most 64 bytes. Outgoing bytes are taken from the window starting at word 0. Incoming bytes are packed little-endian into the window, also starting at word 0, so a write-then-read overwrites its own write data. While a cycle runs, the configuration is locked. Completion, misuse and bad commands are reported through sticky status flags and an optional interrupt line.

The back-end port has three channels, each using valid/ready: a request channel, a write-data channel and a read-data channel. Once the sequencer raises `req_valid`, it holds it and all request fields stable until `req_ready` is seen. It treats `wr_valid`/`wr_data` the same way until `wr_ready`. The back end may stall any channel for any number of cycles. The sequencer raises `rd_ready` only while it still expects read words.

Top module: `pio_seq`

## Requirements
- R1: After reset, every register reads 0, the status register reads 0 and no back-end channel is active.
- R2: Register word addresses: 0 to 15 data window; 16 byte count (bits 6:0 primary length, bits 22:16 read length of a write-then-read); 17 target address (bits 23:0); 18 opcode (bits 7:0); 19 control (bit 0 go, bit 1 interrupt enable); 20 status (bit 0 busy, bit 1 done, bit 2 sequence error, bit 3 command error). The go bit always reads back 0. Writing a 1 to it starts a cycle.
- R3: Opcode 0x18 issues a request of kind 1 (write) with the address and write length. It then sends ceil(len/4) words from data words 0 upward on the write channel and sets done.
- R4: Opcode 0x14 issues a request of kind 0 (read) with read length = count bits 6:0. It stores ceil(len/4) received words into data words 0 upward and sets done.
- R5: Opcode 0x1C issues a request of kind 2. The write length comes from count bits 6:0 and the read length from bits 22:16. The write words are sent first. The read words then fill the window from word 0.
- R6: Opcode 0x13 copies data word 0 into local register address[7:0]. Opcode 0x12 copies local register address[7:0] into data word 0. Neither makes any back-end request.
- R7: A length of 0 or above 64 (either field used by the opcode), or any opcode not listed above, sets done and command error at once and makes no back-end request.
- R8: While busy, a write to any register other than status is dropped and sets the sequence error flag.
- R9: Done, sequence error and command error are cleared by writing 1 to their status bits. A flag being set wins over a clear in the same cycle.
- R10: `irq` is high exactly while done is set and interrupt enable is 1.
- R11: Request fields and write data stay stable while their valid is high and ready is low. At most one of `req_valid`, `wr_valid` and `rd_ready` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register write word address |
| reg_wdata | input | 32 | Register write data |
| reg_rd_addr | input | 5 | Register read word address |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Done interrupt |
| req_valid | output | 1 | Back-end request valid |
| req_ready | input | 1 | Back-end request ready |
| req_kind | output | 2 | 0 read, 1 write, 2 write-then-read |
| req_addr | output | 24 | Target address |
| req_wlen | output | 7 | Bytes to write |
| req_rlen | output | 7 | Bytes to read |
| wr_valid | output | 1 | Write word valid |
| wr_ready | input | 1 | Write word ready |
| wr_data | output | 32 | Write word, little-endian bytes |
| rd_valid | input | 1 | Read word valid |
| rd_ready | output | 1 | Read word ready |
| rd_data | input | 32 | Read word, little-endian bytes |

## Verification
Two things can land in the same cycle: a cycle completes and sets done, and software writes 1 to the done bit to clear it. The bench provokes this with a local-register write, which always takes exactly one cycle after go. It issues the go write and then, in the very next cycle, a status clear. This makes the clear land on the completion edge. Done must read back as 1, and the sequence error must stay 0, because the status register is not locked.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  typedef enum logic [1:0] {
    XK_READ  = 2'd0,
    XK_WRITE = 2'd1,
    XK_WRRD  = 2'd2
  } xfer_kind_e;

  typedef enum logic [2:0] {
    OC_NONE  = 3'd0,
    OC_LRD   = 3'd1,
    OC_LWR   = 3'd2,
    OC_XRD   = 3'd3,
    OC_XWR   = 3'd4,
    OC_XWRRD = 3'd5
  } op_class_e;

  localparam logic [7:0] OPC_LOC_RD = 8'h12;
  localparam logic [7:0] OPC_LOC_WR = 8'h13;
  localparam logic [7:0] OPC_EXT_RD = 8'h14;
  localparam logic [7:0] OPC_EXT_WR = 8'h18;
  localparam logic [7:0] OPC_EXT_WRRD = 8'h1C;

  localparam int unsigned RG_COUNT  = 16;
  localparam int unsigned RG_ADDR   = 17;
  localparam int unsigned RG_OPCODE = 18;
  localparam int unsigned RG_CTRL   = 19;
  localparam int unsigned RG_STATUS = 20;
endpackage

// File: rtl/pio_opdec.sv
module pio_opdec
  import pio_seq_pkg::*;
(
  input  logic [7:0] opcode,
  output op_class_e  op_class
);
  always_comb begin
    case (opcode)
      OPC_LOC_RD:   op_class = OC_LRD;
      OPC_LOC_WR:   op_class = OC_LWR;
      OPC_EXT_RD:   op_class = OC_XRD;
      OPC_EXT_WR:   op_class = OC_XWR;
      OPC_EXT_WRRD: op_class = OC_XWRRD;
      default:      op_class = OC_NONE;
    endcase
  end
endmodule

// File: rtl/pio_subregs.sv
module pio_subregs #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/pio_seq_ctrl.sv
module pio_seq_ctrl
  import pio_seq_pkg::*;
#(
  parameter int unsigned LEN_W = 7,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_local,
  input  xfer_kind_e       kind,
  input  logic [LEN_W-1:0] wlen,
  input  logic [LEN_W-1:0] rlen,
  input  logic             req_ready,
  input  logic             wr_ready,
  input  logic             rd_valid,
  output logic             busy,
  output logic             req_valid,
  output logic             wr_valid,
  output logic             rd_ready,
  output logic [IDX_W-1:0] word_idx,
  output logic             rd_store,
  output logic             loc_fire,
  output logic             fin
);
  localparam int unsigned WLW = LEN_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WR, S_RD, S_LOCAL} st_e;
  st_e st_q;
  logic [IDX_W-1:0] idx_q;
  logic [WLW-1:0] wwords, rwords;
  logic last_w, last_r;

  assign wwords = (WLW'(wlen) + WLW'(3)) >> 2;
  assign rwords = (WLW'(rlen) + WLW'(3)) >> 2;
  assign last_w = (WLW'(idx_q) == wwords - WLW'(1));
  assign last_r = (WLW'(idx_q) == rwords - WLW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          idx_q <= '0;
          st_q  <= is_local ? S_LOCAL : S_REQ;
        end
        S_REQ: if (req_ready) st_q <= (kind == XK_READ) ? S_RD : S_WR;
        S_WR: if (wr_ready) begin
          if (last_w) begin
            idx_q <= '0;
            st_q  <= (kind == XK_WRRD) ? S_RD : S_IDLE;
          end else idx_q <= idx_q + IDX_W'(1);
        end
        S_RD: if (rd_valid) begin
          if (last_r) st_q <= S_IDLE;
          else idx_q <= idx_q + IDX_W'(1);
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign req_valid = (st_q == S_REQ);
  assign wr_valid  = (st_q == S_WR);
  assign rd_ready  = (st_q == S_RD);
  assign word_idx  = idx_q;
  assign rd_store  = rd_ready && rd_valid;
  assign loc_fire  = (st_q == S_LOCAL);
  assign fin = loc_fire
             || (wr_valid && wr_ready && last_w && kind != XK_WRRD)
             || (rd_store && last_r);
endmodule

// File: rtl/pio_seq.sv
module pio_seq
  import pio_seq_pkg::*;
#(
  parameter int unsigned DATA_WORDS = 16,
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned SUB_DEPTH  = 256,
  parameter int unsigned RA_W       = 5,
  localparam int unsigned MAX_BYTES = DATA_WORDS * 4,
  localparam int unsigned LEN_W     = $clog2(MAX_BYTES + 1),
  localparam int unsigned IDX_W     = $clog2(DATA_WORDS),
  localparam int unsigned SUB_AW    = $clog2(SUB_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [RA_W-1:0]   reg_rd_addr,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [1:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_wlen,
  output logic [LEN_W-1:0]  req_rlen,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [31:0]       wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [31:0]       rd_data
);
  logic [31:0]       data_q [DATA_WORDS];
  logic [LEN_W-1:0]  cnt_lo_q, cnt_hi_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        opc_q;
  logic              ie_q, done_q, seq_err_q, cmd_err_q;

  op_class_e  op_class;
  xfer_kind_e kind;
  logic busy, rd_store, loc_fire, fin;
  logic [IDX_W-1:0] word_idx;
  logic [31:0] sub_rdata;

  pio_opdec u_dec (.opcode(opc_q), .op_class(op_class));

  always_comb begin
    case (op_class)
      OC_XWR:   kind = XK_WRITE;
      OC_XWRRD: kind = XK_WRRD;
      default:  kind = XK_READ;
    endcase
  end

  function automatic logic len_ok(input logic [LEN_W-1:0] l);
    return (l != '0) && (int'(l) <= MAX_BYTES);
  endfunction

  logic wr_map, wr_status, go_wr, cmd_ok, start, bad, blocked;
  assign wr_map    = reg_wr_en && (int'(reg_addr) <= RG_STATUS);
  assign wr_status = reg_wr_en && (int'(reg_addr) == RG_STATUS);
  assign blocked   = busy && wr_map && !wr_status;
  assign go_wr     = !busy && reg_wr_en && (int'(reg_addr) == RG_CTRL) && reg_wdata[0];
  assign cmd_ok    = (op_class != OC_NONE) && len_ok(cnt_lo_q)
                  && ((op_class != OC_XWRRD) || len_ok(cnt_hi_q));
  assign start     = go_wr && cmd_ok;
  assign bad       = go_wr && !cmd_ok;

  pio_seq_ctrl #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .is_local((op_class == OC_LRD) || (op_class == OC_LWR)),
    .kind(kind), .wlen(cnt_lo_q),
    .rlen((op_class == OC_XWRRD) ? cnt_hi_q : cnt_lo_q),
    .req_ready(req_ready), .wr_ready(wr_ready), .rd_valid(rd_valid),
    .busy(busy), .req_valid(req_valid), .wr_valid(wr_valid), .rd_ready(rd_ready),
    .word_idx(word_idx), .rd_store(rd_store), .loc_fire(loc_fire), .fin(fin)
  );

  pio_subregs #(.DEPTH(SUB_DEPTH), .DW(32)) u_sub (
    .clk(clk), .we(loc_fire && op_class == OC_LWR),
    .addr(addr_q[SUB_AW-1:0]), .wdata(data_q[0]), .rdata(sub_rdata)
  );

  // data window: software writes when idle, engine writes when busy
  for (genvar g = 0; g < DATA_WORDS; g++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_q[g] <= '0;
      else if (!busy && reg_wr_en && int'(reg_addr) == g) data_q[g] <= reg_wdata;
      else if (rd_store && int'(word_idx) == g) data_q[g] <= rd_data;
      else if (g == 0 && loc_fire && op_class == OC_LRD) data_q[g] <= sub_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo_q <= '0; cnt_hi_q <= '0; addr_q <= '0; opc_q <= '0; ie_q <= 1'b0;
      done_q <= 1'b0; seq_err_q <= 1'b0; cmd_err_q <= 1'b0;
    end else begin
      if (!busy && reg_wr_en) begin
        if (int'(reg_addr) == RG_COUNT) begin
          cnt_lo_q <= reg_wdata[LEN_W-1:0];
          cnt_hi_q <= reg_wdata[16 +: LEN_W];
        end
        if (int'(reg_addr) == RG_ADDR)   addr_q <= reg_wdata[ADDR_W-1:0];
        if (int'(reg_addr) == RG_OPCODE) opc_q  <= reg_wdata[7:0];
        if (int'(reg_addr) == RG_CTRL)   ie_q   <= reg_wdata[1];
      end
      // set beats clear
      done_q    <= (done_q    && !(wr_status && reg_wdata[1])) || fin || bad;
      seq_err_q <= (seq_err_q && !(wr_status && reg_wdata[2])) || blocked;
      cmd_err_q <= (cmd_err_q && !(wr_status && reg_wdata[3])) || bad;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (int'(reg_rd_addr) < DATA_WORDS) reg_rdata = data_q[reg_rd_addr[IDX_W-1:0]];
    else case (int'(reg_rd_addr))
      RG_COUNT:  reg_rdata = (32'(cnt_hi_q) << 16) | 32'(cnt_lo_q);
      RG_ADDR:   reg_rdata = 32'(addr_q);
      RG_OPCODE: reg_rdata = 32'(opc_q);
      RG_CTRL:   reg_rdata = {30'd0, ie_q, 1'b0};
      RG_STATUS: reg_rdata = {28'd0, cmd_err_q, seq_err_q, done_q, busy};
      default:   reg_rdata = '0;
    endcase
  end

  assign irq      = done_q && ie_q;
  assign req_kind = kind;
  assign req_addr = addr_q;
  assign req_wlen = (kind == XK_READ) ? '0 : cnt_lo_q;
  assign req_rlen = (kind == XK_READ) ? cnt_lo_q : ((kind == XK_WRRD) ? cnt_hi_q : '0);
  assign wr_data  = data_q[word_idx];
endmodule

// File: rtl/pio_seq_chk.sv
module pio_seq_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned RA_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [RA_W-1:0]   reg_addr,
  input logic              busy,
  input logic              done_q,
  input logic              seq_err_q,
  input logic              cmd_err_q,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic [ADDR_W-1:0] req_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [31:0]       wr_data,
  input logic              rd_ready
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_kind));

  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data));

  assert_one_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_valid, wr_valid, rd_ready}));

  assert_blocked_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr_en && int'(reg_addr) <= 19 |=> seq_err_q);

  assert_finish_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_q);

  assert_bad_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_err_q) |-> !busy && !req_valid);
endmodule

bind pio_seq pio_seq_chk #(.ADDR_W(ADDR_W), .RA_W(RA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .busy(busy), .done_q(done_q), .seq_err_q(seq_err_q), .cmd_err_q(cmd_err_q),
  .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind), .req_addr(req_addr),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .rd_ready(rd_ready)
);

// File: tb/pio_seq_tb_top.sv
`timescale 1ns/100ps
module pio_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        reg_wr_en = 1'b0;
  logic [4:0]  reg_addr = '0, reg_rd_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, req_valid, req_ready, wr_valid, wr_ready, rd_valid, rd_ready;
  logic [1:0]  req_kind;
  logic [23:0] req_addr;
  logic [6:0]  req_wlen, req_rlen;
  logic [31:0] wr_data, rd_data;

  pio_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata), .irq(irq),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind), .req_addr(req_addr),
    .req_wlen(req_wlen), .req_rlen(req_rlen), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // back-end model state
  bit          mclr = 0;
  int          nreq = 0, stall = 0, ncap = 0, nrd = 0, hold_bad = 0;
  logic [1:0]  m_kind;
  logic [23:0] m_addr, first_addr;
  logic [6:0]  m_wlen, m_rlen;
  logic [31:0] cap [16];

  function automatic logic [31:0] pat(input int n);
    return 32'hA500_0000 | (32'(n) << 8) | 32'(n + 3);
  endfunction

  initial begin req_ready = 0; wr_ready = 0; rd_valid = 0; rd_data = '0; end

  always @(negedge clk) begin
    if (mclr) begin nreq = 0; ncap = 0; nrd = 0; stall = 0; end
    req_ready <= 0; wr_ready <= 0; rd_valid <= 0;
    if (req_valid) begin
      if (stall == 0) first_addr = req_addr;
      else if (req_addr != first_addr) hold_bad++;
      if (stall < 2) stall++;
      else begin
        req_ready <= 1; stall = 0; nreq++;
        m_kind = req_kind; m_addr = req_addr; m_wlen = req_wlen; m_rlen = req_rlen;
      end
    end
    if (wr_valid) begin wr_ready <= 1; if (ncap < 16) cap[ncap] = wr_data; ncap++; end
    if (rd_ready) begin rd_valid <= 1; rd_data <= pat(nrd); nrd++; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_rd_addr = 5'(a); #1; d = reg_rdata;
  endtask

  task automatic model_reset();
    mclr = 1; @(negedge clk); mclr = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); rd(20, s);
      if (!s[0]) return;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a <= 20; a++) begin rd(a, v); chk("R1 reg reset", v, 0); end
    chk("R1 no channel", {req_valid, wr_valid, rd_ready, irq}, 0);
  endtask

  task automatic t_ctrl_map();
    logic [31:0] v;
    wr(19, 32'h2); rd(19, v); chk("R2 ctrl readback", v, 32'h2);
    wr(17, 32'hFF12_3456); rd(17, v); chk("R2 addr field", v, 32'h0012_3456);
    wr(19, 32'h0);
  endtask

  task automatic t_write();
    logic [31:0] v;
    model_reset();
    wr(16, 10); wr(17, 24'h00ABCD);
    for (int i = 0; i < 4; i++) wr(i, 32'h1111_0000 + 32'(i));
    wr(18, 8'h18); wr(19, 1); wait_idle();
    chk("R3 one request", 32'(nreq), 1);
    chk("R3 kind write", 32'(m_kind), 1);
    chk("R3 addr", 32'(m_addr), 32'h00ABCD);
    chk("R3 wlen", 32'(m_wlen), 10);
    chk("R3 word count", 32'(ncap), 3);
    for (int i = 0; i < 3; i++) chk("R3 word data", cap[i], 32'h1111_0000 + 32'(i));
    rd(20, v); chk("R3 done", v & 32'hF, 32'h2);
    rd(19, v); chk("R2 go reads 0", v[0], 0);
    wr(20, 32'hE);
  endtask

  task automatic t_read();
    logic [31:0] v;
    model_reset();
    wr(16, 8); wr(17, 24'h000042); wr(18, 8'h14); wr(19, 1); wait_idle();
    chk("R4 kind read", 32'(m_kind), 0);
    chk("R4 rlen", 32'(m_rlen), 8);
    rd(0, v); chk("R4 word0", v, pat(0));
    rd(1, v); chk("R4 word1", v, pat(1));
    rd(2, v); chk("R4 word2 untouched", v, 32'h1111_0002);
    wr(20, 32'hE);
  endtask

  task automatic t_wrrd();
    logic [31:0] v;
    model_reset();
    wr(0, 32'hDEAD_0001); wr(1, 32'hDEAD_0002);
    wr(16, (12 << 16) | 5); wr(18, 8'h1C); wr(19, 1); wait_idle();
    chk("R5 kind wrrd", 32'(m_kind), 2);
    chk("R5 wlen", 32'(m_wlen), 5);
    chk("R5 rlen", 32'(m_rlen), 12);
    chk("R5 write words", 32'(ncap), 2);
    chk("R5 wr word1", cap[1], 32'hDEAD_0002);
    for (int i = 0; i < 3; i++) begin rd(i, v); chk("R5 read word", v, pat(i)); end
    wr(20, 32'hE);
  endtask

  task automatic t_local();
    logic [31:0] v;
    model_reset();
    wr(0, 32'hCAFE_F00D); wr(16, 4); wr(17, 24'h00_017A); wr(18, 8'h13); wr(19, 1); wait_idle();
    wr(0, 32'h0); wr(18, 8'h12); wr(19, 1); wait_idle();
    rd(0, v); chk("R6 local roundtrip", v, 32'hCAFE_F00D);
    chk("R6 no request", 32'(nreq), 0);
    wr(20, 32'hE);
  endtask

  task automatic t_bad();
    logic [31:0] v;
    model_reset();
    wr(16, 0); wr(18, 8'h14); wr(19, 1);
    rd(20, v); chk("R7 zero length", v & 32'hF, 32'hA);
    wr(20, 32'hE); rd(20, v); chk("R9 w1c clear", v & 32'hF, 0);
    wr(16, 65); wr(19, 1);
    rd(20, v); chk("R7 length 65", v & 32'hF, 32'hA);
    wr(20, 32'hE);
    wr(16, 4); wr(18, 8'h55); wr(19, 1);
    rd(20, v); chk("R7 unknown opcode", v & 32'hF, 32'hA);
    wr(16, 4 | (70 << 16)); wr(18, 8'h1C); wr(20, 32'hE); wr(19, 1);
    rd(20, v); chk("R7 read length 70", v & 32'hF, 32'hA);
    repeat (4) @(negedge clk);
    chk("R7 no request", 32'(nreq), 0);
    wr(20, 32'hE);
  endtask

  task automatic t_seq_err();
    logic [31:0] v;
    model_reset();
    wr(5, 32'h5555_5555); wr(17, 24'h000010);
    wr(16, 8); wr(18, 8'h14); wr(19, 1);
    wr(17, 24'h000099); wr(5, 32'h0);
    wait_idle();
    rd(20, v); chk("R8 seq error set", v & 32'h4, 32'h4);
    rd(17, v); chk("R8 addr kept", v, 32'h10);
    rd(5, v); chk("R8 data kept", v, 32'h5555_5555);
    chk("R8 request addr", 32'(m_addr), 32'h10);
    wr(20, 32'hE);
  endtask

  task automatic t_collide_irq();
    logic [31:0] v;
    wr(19, 32'h2); wr(16, 4); wr(18, 8'h13); wr(17, 24'h5);
    @(negedge clk); reg_wr_en = 1; reg_addr = 19; reg_wdata = 32'h3;
    @(negedge clk); reg_addr = 20; reg_wdata = 32'h2;
    @(negedge clk); reg_wr_en = 0;
    rd(20, v); chk("R9 set beats clear", v & 32'hF, 32'h2);
    chk("R10 irq high", irq, 1);
    wr(19, 0); #1; chk("R10 irq masked", irq, 0);
    wr(20, 32'h2); rd(20, v); chk("R9 done cleared", v & 32'hF, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ctrl_map();
    t_write();
    t_read();
    t_wrrd();
    t_local();
    t_bad();
    t_seq_err();
    t_collide_irq();
    chk("R11 request held", 32'(hold_bad), 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule